// File: doc/BRIEF.md
# Packed Lane Saturating Adder

This block adds two 32-bit words as a vector of small unsigned lanes, which suits per-channel pixel arithmetic where one word packs four 8-bit colour or alpha values. Each lane is summed on its own, so no carry passes from one lane into the next. A lane-width input can pair adjacent bytes into 16-bit lanes for image data that needs more precision. In that case the carry passes between the two bytes of a lane and stops at the lane edge.

A second input chooses between two overflow behaviours for each operation. In wrapping mode a lane keeps the low bits of its sum. In saturating mode a lane that overflows is clamped to all ones. Whatever the mode, a per-byte flag vector reports which lanes overflowed. One cycle after a valid strobe, the operands produce a registered result with its own valid flag. Between strobes the result holds steady.

Top module: `simd_sat_adder`

## Requirements
- R1: With `wide_en`=0 the word is split into four 8-bit lanes (byte i is bits 8i+7..8i), and no carry out of a lane reaches the lane above it.
- R2: With `sat_en`=0 every lane of `out_sum` equals the lane sum modulo 2^lane-width (256 for 8-bit lanes, 65536 for 16-bit lanes).
- R3: With `sat_en`=1 a lane whose sum exceeds its width outputs all ones (8'hFF, or 16'hFFFF for a 16-bit lane).
- R4: With `sat_en`=1 a lane whose sum fits its width outputs the exact sum.
- R5: With `wide_en`=1 the lanes are bits 15..0 and 31..16. The carry out of bit 7 passes into bit 8 within a lane and is blocked at bit 16.
- R6: `out_flags[i]` is 1 exactly when the lane holding byte i overflowed, in either mode. With 16-bit lanes both flag bits of an overflowed lane are 1.
- R7: `out_valid` equals `in_valid` from the previous clock. A synchronous `rst` (active high) clears `out_valid`, `out_sum` and `out_flags` to 0.
- R8: In a cycle with `in_valid`=0 the operands and mode inputs are ignored, and `out_sum` and `out_flags` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and modes valid this cycle |
| in_a | input | 32 | First operand word |
| in_b | input | 32 | Second operand word |
| sat_en | input | 1 | 1 = saturate lanes, 0 = wrap lanes |
| wide_en | input | 1 | 1 = 16-bit lanes, 0 = 8-bit lanes |
| out_valid | output | 1 | Result registered from a valid input |
| out_sum | output | 32 | Lane-wise sum |
| out_flags | output | 4 | Per-byte lane overflow flags |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- holding of the result while no strobe arrives;
- the all-ones clamp on an overflowing byte lane;
- agreement of the byte flags with the operand carries;
- pairing of the flags in 16-bit mode.

Only the bench's directed scenarios can show the exact lane values in every mode combination. Those scenarios cover sums that would carry across a boundary in a full-width add, the carry passing between the two bytes of a 16-bit lane, and back-to-back strobes that mix modes.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

   typedef enum logic {
      LANE_NARROW = 1'b0,
      LANE_WIDE   = 1'b1
   } lane_mode_e;

   typedef enum logic {
      OVF_WRAP  = 1'b0,
      OVF_CLAMP = 1'b1
   } ovf_mode_e;

   function automatic int unsigned count_bytes(int unsigned word_w, int unsigned byte_w);
      return word_w / byte_w;
   endfunction

endpackage

// File: rtl/simd_byte_slice.sv
module simd_byte_slice #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic [BYTE_W-1:0] op_a,
   input  logic [BYTE_W-1:0] op_b,
   input  logic              carry_in,
   output logic [BYTE_W-1:0] part_sum,
   output logic              carry_out
);

   initial begin
      if (BYTE_W < 2) $error("simd_byte_slice: BYTE_W must be at least 2");
   end

   logic [BYTE_W:0] full_sum;

   always_comb begin
      full_sum  = {1'b0, op_a} + {1'b0, op_b} + {{BYTE_W{1'b0}}, carry_in};
      part_sum  = full_sum[BYTE_W-1:0];
      carry_out = full_sum[BYTE_W];
   end

endmodule

// File: rtl/simd_pair_adder.sv
module simd_pair_adder
   import simd_add_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned PAIR_W = 2 * BYTE_W
) (
   input  logic [PAIR_W-1:0] pa,
   input  logic [PAIR_W-1:0] pb,
   input  lane_mode_e        lane_mode,
   output logic [PAIR_W-1:0] psum,
   output logic              lo_carry,
   output logic              hi_carry
);

   logic             link_carry;
   logic [BYTE_W-1:0] lo_sum;
   logic [BYTE_W-1:0] hi_sum;

   // The inner byte boundary passes a carry only in 16-bit lane mode.
   assign link_carry = (lane_mode == LANE_WIDE) & lo_carry;

   simd_byte_slice #(.BYTE_W(BYTE_W)) u_lo (
      .op_a      (pa[BYTE_W-1:0]),
      .op_b      (pb[BYTE_W-1:0]),
      .carry_in  (1'b0),
      .part_sum  (lo_sum),
      .carry_out (lo_carry)
   );

   simd_byte_slice #(.BYTE_W(BYTE_W)) u_hi (
      .op_a      (pa[PAIR_W-1:BYTE_W]),
      .op_b      (pb[PAIR_W-1:BYTE_W]),
      .carry_in  (link_carry),
      .part_sum  (hi_sum),
      .carry_out (hi_carry)
   );

   assign psum = {hi_sum, lo_sum};

endmodule

// File: rtl/simd_sat_stage.sv
module simd_sat_stage
   import simd_add_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NUM_BYTES = WORD_W / BYTE_W,
   localparam int unsigned NUM_PAIRS = NUM_BYTES / 2
) (
   input  logic [WORD_W-1:0]    raw_sum,
   input  logic [NUM_PAIRS-1:0] lo_carry,
   input  logic [NUM_PAIRS-1:0] hi_carry,
   input  lane_mode_e           lane_mode,
   input  ovf_mode_e            ovf_mode,
   output logic [WORD_W-1:0]    lane_res,
   output logic [NUM_BYTES-1:0] lane_ovf
);

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic lo_ovf;
      logic hi_ovf;
      logic lo_clamp;
      logic hi_clamp;

      // In 16-bit mode the carry of the upper byte marks the whole lane.
      assign lo_ovf   = (lane_mode == LANE_WIDE) ? hi_carry[p] : lo_carry[p];
      assign hi_ovf   = hi_carry[p];
      assign lo_clamp = (ovf_mode == OVF_CLAMP) & lo_ovf;
      assign hi_clamp = (ovf_mode == OVF_CLAMP) & hi_ovf;

      assign lane_ovf[2*p]   = lo_ovf;
      assign lane_ovf[2*p+1] = hi_ovf;

      assign lane_res[(2*p)*BYTE_W +: BYTE_W] =
         lo_clamp ? {BYTE_W{1'b1}} : raw_sum[(2*p)*BYTE_W +: BYTE_W];
      assign lane_res[(2*p+1)*BYTE_W +: BYTE_W] =
         hi_clamp ? {BYTE_W{1'b1}} : raw_sum[(2*p+1)*BYTE_W +: BYTE_W];
   end

endmodule

// File: rtl/simd_out_reg.sv
module simd_out_reg #(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned FLAG_W    = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [WORD_W-1:0] d_sum,
   input  logic [FLAG_W-1:0] d_flags,
   output logic              q_valid,
   output logic [WORD_W-1:0] q_sum,
   output logic [FLAG_W-1:0] q_flags
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q_valid <= 1'b0;
         q_sum   <= '0;
         q_flags <= '0;
      end else begin
         q_valid <= load;
         if (load) begin
            q_sum   <= d_sum;
            q_flags <= d_flags;
         end
      end
   end

endmodule

// File: rtl/simd_sat_adder.sv
module simd_sat_adder
   import simd_add_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NUM_BYTES = WORD_W / BYTE_W,
   localparam int unsigned NUM_PAIRS = NUM_BYTES / 2,
   localparam int unsigned PAIR_W    = 2 * BYTE_W
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [WORD_W-1:0]    in_a,
   input  logic [WORD_W-1:0]    in_b,
   input  logic                 sat_en,
   input  logic                 wide_en,
   output logic                 out_valid,
   output logic [WORD_W-1:0]    out_sum,
   output logic [NUM_BYTES-1:0] out_flags
);

   if (WORD_W % PAIR_W != 0) begin : g_bad_width
      initial $error("simd_sat_adder: WORD_W must be a multiple of 2*BYTE_W");
   end
   if (count_bytes(WORD_W, BYTE_W) != NUM_BYTES) begin : g_bad_count
      initial $error("simd_sat_adder: byte count mismatch");
   end

   lane_mode_e           lane_mode;
   ovf_mode_e            ovf_mode;
   logic [WORD_W-1:0]    raw_sum;
   logic [NUM_PAIRS-1:0] lo_carry;
   logic [NUM_PAIRS-1:0] hi_carry;
   logic [WORD_W-1:0]    lane_res;
   logic [NUM_BYTES-1:0] lane_ovf;

   assign lane_mode = wide_en ? LANE_WIDE : LANE_NARROW;
   assign ovf_mode  = sat_en  ? OVF_CLAMP : OVF_WRAP;

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pairs
      simd_pair_adder #(.BYTE_W(BYTE_W)) u_pair (
         .pa        (in_a[p*PAIR_W +: PAIR_W]),
         .pb        (in_b[p*PAIR_W +: PAIR_W]),
         .lane_mode (lane_mode),
         .psum      (raw_sum[p*PAIR_W +: PAIR_W]),
         .lo_carry  (lo_carry[p]),
         .hi_carry  (hi_carry[p])
      );
   end

   simd_sat_stage #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_sat (
      .raw_sum   (raw_sum),
      .lo_carry  (lo_carry),
      .hi_carry  (hi_carry),
      .lane_mode (lane_mode),
      .ovf_mode  (ovf_mode),
      .lane_res  (lane_res),
      .lane_ovf  (lane_ovf)
   );

   simd_out_reg #(.WORD_W(WORD_W), .FLAG_W(NUM_BYTES)) u_reg (
      .clk     (clk),
      .rst     (rst),
      .load    (in_valid),
      .d_sum   (lane_res),
      .d_flags (lane_ovf),
      .q_valid (out_valid),
      .q_sum   (out_sum),
      .q_flags (out_flags)
   );

endmodule

// File: rtl/simd_sat_adder_chk.sv
module simd_sat_adder_chk #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned NUM_BYTES = WORD_W / BYTE_W,
   localparam int unsigned NUM_PAIRS = NUM_BYTES / 2
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 in_valid,
   input logic [WORD_W-1:0]    in_a,
   input logic [WORD_W-1:0]    in_b,
   input logic                 sat_en,
   input logic                 wide_en,
   input logic                 out_valid,
   input logic [WORD_W-1:0]    out_sum,
   input logic [NUM_BYTES-1:0] out_flags
);

   logic [NUM_BYTES-1:0] byte_cy;

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_cy
      logic [BYTE_W:0] s;
      assign s = {1'b0, in_a[i*BYTE_W +: BYTE_W]} + {1'b0, in_b[i*BYTE_W +: BYTE_W]};
      assign byte_cy[i] = s[BYTE_W];
   end

   assert_valid_delay_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid == $past(in_valid));

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_sum) && $stable(out_flags)));

   for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
      assert_clamp_ones_R3: assert property (@(posedge clk) disable iff (rst)
         (in_valid && sat_en && !wide_en && byte_cy[i])
         |=> (out_sum[i*BYTE_W +: BYTE_W] == {BYTE_W{1'b1}}));

      assert_byte_flag_R6: assert property (@(posedge clk) disable iff (rst)
         (in_valid && !wide_en) |=> (out_flags[i] == $past(byte_cy[i])));
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assert_pair_flags_R5: assert property (@(posedge clk) disable iff (rst)
         (in_valid && wide_en) |=> (out_flags[2*p] == out_flags[2*p+1]));
   end

endmodule

bind simd_sat_adder simd_sat_adder_chk #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_a      (in_a),
   .in_b      (in_b),
   .sat_en    (sat_en),
   .wide_en   (wide_en),
   .out_valid (out_valid),
   .out_sum   (out_sum),
   .out_flags (out_flags)
);

// File: tb/simd_sat_adder_test.sv
module simd_sat_adder_test;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned NB     = 4;

   typedef struct packed {
      logic [WORD_W-1:0] sum;
      logic [NB-1:0]     flags;
      logic [15:0]       tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              in_valid = 1'b0;
   logic [WORD_W-1:0] in_a = '0;
   logic [WORD_W-1:0] in_b = '0;
   logic              sat_en = 1'b0;
   logic              wide_en = 1'b0;
   logic              out_valid;
   logic [WORD_W-1:0] out_sum;
   logic [NB-1:0]     out_flags;

   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;
   bit   mon_on = 1'b0;
   exp_t sb_q[$];
   exp_t last_exp;

   always #4 clk = ~clk;

   simd_sat_adder uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
      .sat_en(sat_en), .wide_en(wide_en), .out_valid(out_valid),
      .out_sum(out_sum), .out_flags(out_flags)
   );

   function automatic exp_t model(logic [31:0] a, logic [31:0] b, logic sat, logic wide,
                                  logic [15:0] tag);
      exp_t e;
      e.tag = tag;
      if (!wide) begin
         for (int i = 0; i < 4; i++) begin
            logic [8:0] s;
            s = {1'b0, a[8*i +: 8]} + {1'b0, b[8*i +: 8]};
            e.sum[8*i +: 8] = (sat && s[8]) ? 8'hFF : s[7:0];
            e.flags[i] = s[8];
         end
      end else begin
         for (int k = 0; k < 2; k++) begin
            logic [16:0] s;
            s = {1'b0, a[16*k +: 16]} + {1'b0, b[16*k +: 16]};
            e.sum[16*k +: 16] = (sat && s[16]) ? 16'hFFFF : s[15:0];
            e.flags[2*k]   = s[16];
            e.flags[2*k+1] = s[16];
         end
      end
      return e;
   endfunction

   task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic sat,
                        input logic wide, input logic [15:0] tag);
      @(negedge clk);
      in_valid = 1'b1;
      in_a = a; in_b = b; sat_en = sat; wide_en = wide;
      sb_q.push_back(model(a, b, sat, wide, tag));
   endtask

   task automatic idle(input logic [31:0] junk);
      @(negedge clk);
      in_valid = 1'b0;
      in_a = junk; in_b = ~junk; sat_en = junk[0]; wide_en = junk[1];
   endtask

   // Monitor: pops the scoreboard on every valid result, checks holding otherwise.
   always @(negedge clk) begin
      if (mon_on) begin
         if (out_valid) begin
            checks++;
            if (sb_q.size() == 0) begin
               errors++;
               $display("FAIL R7: out_valid=1 with no pending item (actual 1, expected 0)");
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               if (out_sum !== e.sum || out_flags !== e.flags) begin
                  errors++;
                  $display("FAIL %s: sum=%h flags=%b expected sum=%h flags=%b",
                           e.tag, out_sum, out_flags, e.sum, e.flags);
               end
               last_exp = e;
            end
         end else begin
            checks++;
            if (out_sum !== last_exp.sum || out_flags !== last_exp.flags) begin
               errors++;
               $display("FAIL R8: idle sum=%h flags=%b expected sum=%h flags=%b",
                        out_sum, out_flags, last_exp.sum, last_exp.flags);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish (actual hung, expected done)");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R7: reset state
      checks++;
      if (out_valid !== 1'b0 || out_sum !== '0 || out_flags !== '0) begin
         errors++;
         $display("FAIL R7: reset valid=%b sum=%h flags=%b expected 0/0/0",
                  out_valid, out_sum, out_flags);
      end
      last_exp = '0;
      mon_on = 1'b1;

      // R1/R2: narrow wrap with lanes that would carry in a full add
      drive(32'h80FF_7F01, 32'h8001_0101, 1'b0, 1'b0, "R1");
      idle(32'hDEAD_BEEF);                               // R8 hold
      drive(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, "R2");
      // R3: clamp on overflow, R4: exact sums in saturating mode
      drive(32'h80FF_7F01, 32'h8001_0101, 1'b1, 1'b0, "R3");
      drive(32'h1020_3040, 32'h0102_0304, 1'b1, 1'b0, "R4");
      drive(32'hFF00_FE01, 32'h01FF_01FE, 1'b1, 1'b0, "R4");
      idle(32'h1234_5678);
      // R5: 16-bit lanes, carry crosses bit 8, blocked at bit 16
      drive(32'h00FF_FFFF, 32'h0001_0001, 1'b0, 1'b1, "R5");
      drive(32'h00FF_00FF, 32'h0001_0001, 1'b1, 1'b1, "R5");
      drive(32'hFFFF_8000, 32'h0001_8000, 1'b1, 1'b1, "R6");
      drive(32'h8000_FFFF, 32'h8000_0000, 1'b0, 1'b1, "R6");
      idle(32'h0F0F_0F0F);
      idle(32'hF0F0_F0F0);
      // R6: flags in each mode; mixed back-to-back modes
      drive(32'h0080_8000, 32'h0080_8000, 1'b0, 1'b0, "R6");
      drive(32'h0080_8000, 32'h0080_8000, 1'b1, 1'b1, "R6");

      lfsr = 32'hACE1_2468;
      for (int n = 0; n < 40; n++) begin
         logic [31:0] a;
         a = lfsr;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         drive(a, lfsr, lfsr[3], lfsr[7], "R2");
         if (lfsr[5]) idle(lfsr ^ 32'h5A5A_5A5A);
      end

      idle(32'h0);
      idle(32'h1);
      idle(32'h2);
      checks++;
      if (sb_q.size() != 0) begin
         errors++;
         $display("FAIL R7: %0d results never appeared (expected 0)", sb_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule